// File: doc/BRIEF.md
# Grouped Pulse Arrival Timestamper

This block records when pulses arrive on a large set of slow, asynchronous sensor lines. One free-running binary counter runs on the system clock and is shared by every channel. Each sensor line is brought into the clock domain and passed through a rising-edge detector. The first rising edge seen on a channel copies the counter into that channel's capture register and sets its valid flag. The host subtracts captured values to get arrival-time differences.

Channels are grouped in fours, and each group of four belongs to one physical event. A group is ready once all four of its channels hold a timestamp. The interrupt line is raised when any ready group has its enable bit set. The host then reads the four capture registers of that group and writes a 1 to the group's status bit. That write re-arms the four channels for the next event.

The host port is a plain register port with no back-pressure. A read strobe with an address returns data on `host_rdata` after the next clock edge, and `host_rdata` holds that value until the next read. A write strobe takes effect at the next edge. The default build has 10 groups of 4 channels, a 24-bit counter and a 32-bit host data word.

Top module: `pulse_stamp_top`

## Requirements
- R1: The counter resets to 0, advances by one on every clock edge, and wraps from all ones to 0. A rollover between two pulses shows up only as a modular difference in the stamps.
- R2: The first edge to see the input high is edge k. The channel then stores the counter value present between edges k+1 and k+2, which is the value the counter held when the input was first high plus 2, modulo 2^CNT_W.
- R3: Only a low-to-high transition captures. A line held high after its group is cleared does not capture again until it has gone low and risen again.
- R4: While a channel's valid flag is set, further pulses on it are ignored and its first timestamp is kept.
- R5: Group g covers channels 4g to 4g+3. Its ready bit is set while all four valid flags are set. The ready bits read back in bits [NUM_GROUPS-1:0] of address NUM_CH (40), and the other bits read 0.
- R6: Writing address NUM_CH with bit g set clears the four valid flags of group g and therefore its ready bit. Bits written as 0 have no effect. Stamp values are kept, and only their valid bit reads 0.
- R7: The interrupt-enable register at address NUM_CH+1 is read/write in bits [NUM_GROUPS-1:0]. `irq` is high one edge after some group is both ready and enabled. A ready group whose enable bit is 0 does not raise `irq`.
- R8: Reading address c, with c below NUM_CH, returns the stamp of channel c in bits [CNT_W-1:0] and its valid flag in bit 31, with all other bits 0. Unmapped addresses read 0. `host_rdata` changes only after an edge with `host_rd` high.
- R9: After reset, all valid flags, stamps, enables, `irq` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the timestamp counter |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | NUM_CH (40) | Asynchronous sensor pulse lines |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | ADDR_W (6) | Register address |
| host_wdata | input | DW (32) | Write data |
| host_rdata | output | DW (32) | Registered read data |
| irq | output | 1 | Some enabled group holds four timestamps |

## Verification
Several properties are checked on every cycle. The counter steps by one with wrap. The edge detector never fires on two cycles in a row. A set valid flag and its stored stamp stay unchanged until a clear. A valid flag rises only after a detected edge. `irq` stays low while no group is enabled. Read data moves only after a read strobe. Other behaviour can only be shown by the bench's scenarios. These are the exact stamp value relative to pulse arrival, group completion and clearing, masked interrupts, rollover of a narrowed counter, and a line held high across a clear.

// File: rtl/pst_pkg.sv
package pst_pkg;
  // Read-path selector in the host register block
  typedef enum logic [1:0] {
    SEL_STAMP  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_e;

  localparam int unsigned HOST_DW = 32;
endpackage

// File: rtl/pst_sync_edge.sv
module pst_sync_edge #(
  parameter int unsigned NCH    = 40,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] async_i,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] stage_q [STAGES];
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign rise_o = stage_q[STAGES-1] & ~prev_q;

  for (genvar c = 0; c < int'(NCH); c++) begin : g_chk
    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[c] |=> !rise_o[c]);
  end
endmodule

// File: rtl/pst_channel.sv
module pst_channel #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic             valid_o
);
  logic accept;

  // a clear in the same cycle re-arms before the edge is considered
  assign accept = rise_i & (~valid_o | clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_o <= '0;
      valid_o <= 1'b0;
    end else if (accept) begin
      stamp_o <= cnt_i;
      valid_o <= 1'b1;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  // R4
  keep_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_i |=> valid_o);
  // R4
  keep_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_i |=> $stable(stamp_o));
  // R2
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(rise_i));
endmodule

// File: rtl/pst_group.sv
module pst_group #(
  parameter int unsigned NUM_GROUPS = 10,
  parameter int unsigned GROUP_SIZE = 4,
  localparam int unsigned NCH = NUM_GROUPS * GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        valid_i,
  input  logic [NUM_GROUPS-1:0] en_i,
  output logic [NUM_GROUPS-1:0] ready_o,
  output logic                  irq_o
);
  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_ready
    assign ready_o[g] = &valid_i[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(ready_o & en_i);
  end

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/pulse_stamp_top.sv
module pulse_stamp_top #(
  parameter int unsigned NUM_GROUPS = 10,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned DW         = pst_pkg::HOST_DW,
  parameter int unsigned ADDR_W     = $clog2(NUM_GROUPS * GROUP_SIZE + 2)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GROUPS*GROUP_SIZE-1:0]  pulse_in,
  input  logic                              host_rd,
  input  logic                              host_wr,
  input  logic [ADDR_W-1:0]                 host_addr,
  input  logic [DW-1:0]                     host_wdata,
  output logic [DW-1:0]                     host_rdata,
  output logic                              irq
);
  import pst_pkg::*;

  localparam int unsigned NCH      = NUM_GROUPS * GROUP_SIZE;
  localparam int unsigned ST_ADDR  = NCH;
  localparam int unsigned EN_ADDR  = NCH + 1;

  // ---------------- shared counter ----------------
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // R1
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // ---------------- input conditioning ----------------
  logic [NCH-1:0] rise;
  pst_sync_edge #(.NCH(NCH), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pulse_in),
    .rise_o  (rise)
  );

  // ---------------- host write decode ----------------
  logic                  wr_status, wr_enable;
  logic [NUM_GROUPS-1:0] clr_grp;
  logic [NUM_GROUPS-1:0] en_q;

  assign wr_status = host_wr && (host_addr == ADDR_W'(ST_ADDR));
  assign wr_enable = host_wr && (host_addr == ADDR_W'(EN_ADDR));
  assign clr_grp   = wr_status ? host_wdata[NUM_GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= host_wdata[NUM_GROUPS-1:0];
  end

  // ---------------- capture channels ----------------
  logic [NCH-1:0][CNT_W-1:0] stamps;
  logic [NCH-1:0]            valids;

  for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
    pst_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise[c]),
      .clr_i   (clr_grp[c / GROUP_SIZE]),
      .cnt_i   (cnt_q),
      .stamp_o (stamps[c]),
      .valid_o (valids[c])
    );
  end

  // ---------------- group tracking ----------------
  logic [NUM_GROUPS-1:0] ready;
  pst_group #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valids),
    .en_i    (en_q),
    .ready_o (ready),
    .irq_o   (irq)
  );

  // ---------------- host read path ----------------
  rd_sel_e       rd_sel;
  logic [DW-1:0] rd_word;

  always_comb begin
    if (int'(host_addr) < int'(NCH))           rd_sel = SEL_STAMP;
    else if (host_addr == ADDR_W'(ST_ADDR))    rd_sel = SEL_STATUS;
    else if (host_addr == ADDR_W'(EN_ADDR))    rd_sel = SEL_ENABLE;
    else                                       rd_sel = SEL_NONE;
  end

  always_comb begin
    rd_word = '0;
    unique case (rd_sel)
      SEL_STAMP: begin
        rd_word[CNT_W-1:0] = stamps[host_addr];
        rd_word[DW-1]      = valids[host_addr];
      end
      SEL_STATUS: rd_word[NUM_GROUPS-1:0] = ready;
      SEL_ENABLE: rd_word[NUM_GROUPS-1:0] = en_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_word;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/pulse_stamp_top_bench.sv
module pulse_stamp_top_bench;
  localparam int NG = 10, GS = 4, NCH = NG * GS;
  localparam int CW = 12;
  localparam int M  = 1 << CW;
  localparam int DW = 32, AW = 6;
  localparam int ST_ADDR = NCH, EN_ADDR = NCH + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] pulse = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int unsigned tb_cnt;
  int unsigned exp_stamp [NCH];
  bit          exp_valid [NCH];
  bit [NG-1:0] exp_en;

  always #5 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) tb_cnt <= 0;
    else        tb_cnt <= (tb_cnt + 1) % M;

  pulse_stamp_top #(.CNT_W(CW)) u_pulse_stamp_top (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  function automatic bit [NG-1:0] exp_ready();
    bit [NG-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = exp_valid[4*g] & exp_valid[4*g+1] & exp_valid[4*g+2] & exp_valid[4*g+3];
    return r;
  endfunction

  function automatic logic [31:0] exp_word(int ch);
    logic [31:0] w = '0;
    w[CW-1:0] = exp_stamp[ch][CW-1:0];
    w[31]     = exp_valid[ch];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(int a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = AW'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (a == ST_ADDR)
      for (int c = 0; c < NCH; c++) if (d[c/GS]) exp_valid[c] = 0;
    if (a == EN_ADDR) exp_en = d[NG-1:0];
    @(negedge clk);
  endtask

  task automatic fire(int ch);
    pulse[ch] = 1'b1;
    if (!exp_valid[ch]) begin
      exp_stamp[ch] = (tb_cnt + 2) % M;
      exp_valid[ch] = 1;
    end
    repeat (3) @(negedge clk);
    pulse[ch] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_group(int g, string req);
    logic [31:0] d;
    for (int k = 0; k < GS; k++) begin
      rd(g*GS + k, d);
      check(req, d, exp_word(g*GS + k));
    end
  endtask

  task automatic check_status();
    logic [31:0] d;
    rd(ST_ADDR, d);
    check("R5 status", d, 32'(exp_ready()));
    check("R7 irq", 32'(irq), 32'(|(exp_ready() & exp_en)));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin exp_stamp[c] = 0; exp_valid[c] = 0; end
    exp_en = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irq", 32'(irq), 0);
    check("R9 rdata", host_rdata, 0);
    rd(ST_ADDR, d); check("R9 status", d, 0);
    rd(EN_ADDR, d); check("R9 enable", d, 0);
    rd(7, d);       check("R9 stamp", d, 0);

    // R7 enable all groups except 9, read back
    wr(EN_ADDR, 32'h1FF);
    rd(EN_ADDR, d); check("R7 enable readback", d, 32'h1FF);
    // R8 unmapped address
    rd(63, d); check("R8 unmapped", d, 0);

    // random rounds: R2, R4, R5, R6, R7
    for (int r = 0; r < 30; r++) begin
      int g = $urandom % NG;
      int nk = ($urandom % 4 == 0) ? 3 : 4;
      for (int k = 0; k < nk; k++) begin
        repeat ($urandom % 8) @(negedge clk);
        fire(g*GS + k);
      end
      if ($urandom % 2) fire(g*GS + ($urandom % GS));   // R4 repeat pulse ignored
      check_group(g, "R2/R4 stamp");
      check_status();
      if ($urandom % 2) begin
        wr(ST_ADDR, 32'(1) << g);                       // R6 clear
        check_status();
        check_group(g, "R6 cleared valid");
      end
    end
    wr(ST_ADDR, 32'h3FF);
    check_status();

    // R7 masked group: group 9 disabled
    for (int k = 0; k < GS; k++) fire(36 + k);
    check_status();
    check("R7 masked irq low", 32'(irq), 0);
    wr(EN_ADDR, 32'h200);
    check("R7 enabled irq high", 32'(irq), 1);
    wr(ST_ADDR, 32'h200);
    check("R6 clear drops irq", 32'(irq), 0);

    // R3 level held across a clear does not recapture
    pulse[4] = 1'b1;
    exp_stamp[4] = (tb_cnt + 2) % M; exp_valid[4] = 1;
    repeat (4) @(negedge clk);
    wr(ST_ADDR, 32'h2);
    repeat (5) @(negedge clk);
    rd(4, d); check("R3 held level no recapture", d, exp_word(4));
    pulse[4] = 1'b0;
    repeat (2) @(negedge clk);
    fire(4);
    rd(4, d); check("R3 fresh edge captures", d, exp_word(4));

    // R1 counter wrap
    wr(ST_ADDR, 32'h1);
    while (tb_cnt != M - 1) @(negedge clk);
    fire(0);
    rd(0, d); check("R1 wrap stamp", d, exp_word(0));
    check("R1 wrapped value", 32'(exp_stamp[0]), 1);
    fire(1);
    rd(1, d); check("R1 after wrap", d, exp_word(1));

    done = 1;
    finish_run();
  end
endmodule